// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits beside a small processor core and decides which interrupt the core services next. It takes sixteen peripheral request lines and one non-maskable request line. A programmable selector routes the peripheral lines onto twelve maskable CPU interrupts, numbered 4 to 15. Every request line passes through a pulse qualifier. A qualified pulse, or a software write to a set register, raises a pending flag. Software can drop pending flags through a clear register. Each maskable interrupt has its own enable bit. A separate non-maskable-enable bit and a global enable gate all maskable service.

Each clock, a fixed-priority picker looks at the pending flags. When the winning request may be serviced, the block runs the entry sequence in that same clock edge. It drops the flag, and for a maskable interrupt it saves the global enable into a previous-enable bit, clears the global enable and stores the core's return address. For a non-maskable interrupt it stores the return address in a separate register. On the next cycle it presents a one-cycle acknowledge, the interrupt number, and the vector address. The vector address is a relocatable table base plus 32 bytes per interrupt number. A return strobe from the core restores the global enable from the saved copy. All state can be read and written through a 4-bit-addressed register port with a combinational read path.

Register port map (word index on `reg_addr_i`): 0 control (bit 0 global enable, bit 1 previous enable); 1 enables (bit 1 non-maskable enable, bits 4..15 per-interrupt enables); 2 pending flags (read only); 3 set (write only, reads 0); 4 clear (write only, reads 0); 5 table base (bits 31..10 stored); 6 selector word for interrupts 4..9; 7 selector word for interrupts 10..15; 8 maskable return address; 9 non-maskable return address. Any other index reads 0.

Top module: `vec_intc`

## Requirements
- R1: After reset, `ack_o`=0, `inum_o`=0 and `vec_o`=0, and the control, enable, flag, table-base and both selector registers all read 0.
- R2: A request line, idle high, produces an event only after it is sampled low on at least 2 rising edges and then high on 2 rising edges. The flag is set on the edge after the second high sample. A line that is low for only one sample produces no event. The non-maskable line is qualified in the same way and feeds flag bit 1.
- R3: Each selector word holds six 4-bit fields at bits 0-3, 5-8, 10-13, 16-19, 21-24 and 26-29. Fields are in ascending interrupt order: word 6 holds interrupts 4..9 and word 7 holds interrupts 10..15. The other bits read 0. A qualified event on source line s sets the flag of every maskable interrupt whose field holds s.
- R4: Flags are read only, and writes to index 2 are ignored. Writing index 3 sets the flags at every 1 bit, and writing index 4 clears them. Flag bits 0, 2 and 3 always read 0. A hardware event and a clear of the same bit in the same cycle leave the bit set.
- R5: Maskable interrupt n is taken only when the global enable is 1, enable bit 1 is 1, enable bit n is 1, flag n is 1, and no higher-priority flag is pending, even a disabled one.
- R6: The priority order is flag 1 (non-maskable) first, then interrupts 4, 5, ... 15. At most one interrupt is taken per clock.
- R7: Taking a maskable interrupt clears its flag, copies the global enable into the previous-enable bit, clears the global enable and loads the maskable return register from `ret_addr_i`. Taking the non-maskable interrupt clears flag 1, loads the non-maskable return register and leaves the control register unchanged.
- R8: On the cycle after an interrupt is taken, `ack_o` is 1 for one cycle, `inum_o` is n, and `vec_o` = table base + 32*n. The table base keeps only bits 31..10, and its lower bits read 0.
- R9: A pulse on `rti_i` copies the previous-enable bit into the global enable and leaves the previous-enable bit unchanged.
- R10: Writing the control register never changes the enable register, and the enable bits 0, 2 and 3 read 0.
- R11: The non-maskable interrupt is taken whenever flag 1 is pending, whatever the global enable and the enable bits hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 16 | Peripheral request lines, idle high |
| nmi_i | input | 1 | Non-maskable request line, idle high |
| ret_addr_i | input | 32 | Return address offered by the core |
| rti_i | input | 1 | Return-from-interrupt strobe |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| ack_o | output | 1 | One-cycle acknowledge of a taken interrupt |
| inum_o | output | 4 | Number of the interrupt taken |
| vec_o | output | 32 | Vector address of the interrupt taken |

## Verification
Assertions check several properties on every cycle:
- the reserved flag bits stay zero;
- every acknowledge has its enable conditions in the previous cycle and no higher-priority flag pending at that time;
- a maskable entry leaves the global enable cleared and the previous enable equal to the old global enable;
- a return strobe restores the global enable;
- a qualified event lasts a single cycle.

Only the bench's scenarios can show other behaviours:
- the exact pulse-width rule of the qualifier;
- routing through selector fields;
- the race between an event and a clear;
- blocking by a disabled higher flag;
- vector arithmetic against a relocated base;
- the order in which a random set of pending interrupts drains.

// File: rtl/vic_pkg.sv
package vic_pkg;
   localparam int unsigned NUM_CPU_INT    = 16;
   localparam int unsigned FIRST_MASKABLE = 4;
   localparam int unsigned NMI_NUM        = 1;
   localparam int unsigned FIELDS_PER_WORD = 6;
   localparam logic [15:0] IMPL_MASK      = 16'hFFF2;

   typedef enum logic [3:0] {
      RA_CTRL  = 4'd0,
      RA_EN    = 4'd1,
      RA_FLAG  = 4'd2,
      RA_SET   = 4'd3,
      RA_CLR   = 4'd4,
      RA_BASE  = 4'd5,
      RA_SELLO = 4'd6,
      RA_SELHI = 4'd7,
      RA_RET   = 4'd8,
      RA_NRET  = 4'd9
   } reg_idx_e;

   // lowest bit of selector field f (gap bit after each field, extra gap at mid-word)
   function automatic int unsigned fld_lsb(int unsigned f, int unsigned w);
      return f * (w + 1) + ((f >= 3) ? 1 : 0);
   endfunction

   function automatic logic [31:0] sel_word_mask(int unsigned w);
      logic [31:0] m;
      m = '0;
      for (int unsigned f = 0; f < FIELDS_PER_WORD; f++)
         for (int unsigned b = 0; b < w; b++)
            m[fld_lsb(f, w) + b] = 1'b1;
      return m;
   endfunction

   // flags that outrank interrupt n
   function automatic logic [15:0] higher_mask(logic [3:0] n);
      logic [15:0] m;
      m = '0;
      if (n != 4'(NMI_NUM)) begin
         m[NMI_NUM] = 1'b1;
         for (int unsigned i = FIRST_MASKABLE; i < NUM_CPU_INT; i++)
            if (i < 32'(n)) m[i] = 1'b1;
      end
      return m;
   endfunction
endpackage

// File: rtl/vic_pin_qual.sv
module vic_pin_qual #(
   parameter int unsigned N        = 17,
   parameter int unsigned LOW_CYC  = 2,
   parameter int unsigned HIGH_CYC = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] pin_i,
   output logic [N-1:0] evt_o
);
   localparam int unsigned WIN = LOW_CYC + HIGH_CYC;
   localparam logic [WIN-1:0] PAT = WIN'((64'd1 << HIGH_CYC) - 64'd1);

   if (LOW_CYC < 1 || HIGH_CYC < 1) begin : g_bad
      $error("vic_pin_qual: LOW_CYC and HIGH_CYC must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_line
      logic [WIN-1:0] samp_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) samp_q <= '1;
         else        samp_q <= {samp_q[WIN-2:0], pin_i[i]};
      end
      assign evt_o[i] = (samp_q == PAT);

      a_r2_evt_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
         evt_o[i] |=> !evt_o[i]);
   end
endmodule

// File: rtl/vic_src_route.sv
module vic_src_route #(
   parameter int unsigned NUM_SRC = 16,
   parameter int unsigned SEL_W   = 4
) (
   input  logic [NUM_SRC-1:0] src_evt_i,
   input  logic [31:0]        sel_lo_i,
   input  logic [31:0]        sel_hi_i,
   output logic [15:0]        cpu_evt_o
);
   import vic_pkg::*;

   assign cpu_evt_o[FIRST_MASKABLE-1:0] = '0;

   for (genvar k = FIRST_MASKABLE; k < NUM_CPU_INT; k++) begin : g_int
      localparam int unsigned IDX = k - FIRST_MASKABLE;
      localparam int unsigned LSB = fld_lsb(IDX % FIELDS_PER_WORD, SEL_W);
      logic [SEL_W-1:0] sel;
      if (IDX < FIELDS_PER_WORD) begin : g_lo
         assign sel = sel_lo_i[LSB +: SEL_W];
      end else begin : g_hi
         assign sel = sel_hi_i[LSB +: SEL_W];
      end
      assign cpu_evt_o[k] = src_evt_i[sel];
   end
endmodule

// File: rtl/vic_prio_pick.sv
module vic_prio_pick (
   input  logic [15:0] flag_i,
   input  logic [15:0] en_i,
   input  logic        gie_i,
   output logic        take_o,
   output logic [3:0]  num_o
);
   import vic_pkg::*;
   logic any;

   always_comb begin
      num_o = '0;
      for (int i = NUM_CPU_INT - 1; i >= int'(FIRST_MASKABLE); i--)
         if (flag_i[i]) num_o = 4'(i);
      if (flag_i[NMI_NUM]) num_o = 4'(NMI_NUM);
   end

   assign any    = |(flag_i & IMPL_MASK);
   assign take_o = any && ((num_o == 4'(NMI_NUM)) ||
                           (gie_i && en_i[NMI_NUM] && en_i[num_o]));
endmodule

// File: rtl/vec_intc.sv
module vec_intc #(
   parameter int unsigned NUM_SRC      = 16,
   parameter int unsigned SRC_SEL_W    = 4,
   parameter int unsigned ADDR_W       = 32,
   parameter int unsigned QUAL_LOW     = 2,
   parameter int unsigned QUAL_HIGH    = 2,
   parameter int unsigned ENTRY_BYTES  = 32,
   parameter int unsigned TABLE_ALIGN_W = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_i,
   input  logic               nmi_i,
   input  logic [ADDR_W-1:0]  ret_addr_i,
   input  logic               rti_i,
   input  logic               reg_we_i,
   input  logic [3:0]         reg_addr_i,
   input  logic [31:0]        reg_wdata_i,
   output logic [31:0]        reg_rdata_o,
   output logic               ack_o,
   output logic [3:0]         inum_o,
   output logic [ADDR_W-1:0]  vec_o
);
   import vic_pkg::*;

   localparam int unsigned ENTRY_SH = $clog2(ENTRY_BYTES);
   localparam logic [31:0] SEL_MASK = sel_word_mask(SRC_SEL_W);

   if (NUM_SRC != (1 << SRC_SEL_W)) begin : g_bad_src
      $error("vec_intc: NUM_SRC must equal 2**SRC_SEL_W");
   end
   if (ADDR_W != 32) begin : g_bad_aw
      $error("vec_intc: ADDR_W must match the 32-bit register port");
   end
   if ((NUM_CPU_INT * ENTRY_BYTES) > (1 << TABLE_ALIGN_W)) begin : g_bad_tab
      $error("vec_intc: table does not fit its alignment");
   end

   // ---------------- state ----------------
   logic [15:0]                      flag_q, en_q;
   logic                             gie_q, pgie_q;
   logic [ADDR_W-1:TABLE_ALIGN_W]    base_q;
   logic [31:0]                      sel_lo_q, sel_hi_q;
   logic [ADDR_W-1:0]                irp_q, nrp_q;
   logic                             ack_q;
   logic [3:0]                       inum_q;
   logic [ADDR_W-1:0]                vec_q;

   // ---------------- request path ----------------
   logic [NUM_SRC:0] q_evt;
   logic [15:0]      cpu_evt, hw_evt;
   logic             take;
   logic [3:0]       take_num;
   logic             take_nmi;

   vic_pin_qual #(.N(NUM_SRC + 1), .LOW_CYC(QUAL_LOW), .HIGH_CYC(QUAL_HIGH)) u_qual (
      .clk(clk), .rst_n(rst_n), .pin_i({nmi_i, src_i}), .evt_o(q_evt));

   vic_src_route #(.NUM_SRC(NUM_SRC), .SEL_W(SRC_SEL_W)) u_route (
      .src_evt_i(q_evt[NUM_SRC-1:0]), .sel_lo_i(sel_lo_q), .sel_hi_i(sel_hi_q),
      .cpu_evt_o(cpu_evt));

   vic_prio_pick u_pick (
      .flag_i(flag_q), .en_i(en_q), .gie_i(gie_q), .take_o(take), .num_o(take_num));

   always_comb begin
      hw_evt = cpu_evt;
      hw_evt[NMI_NUM] = q_evt[NUM_SRC];
   end
   assign take_nmi = take && (take_num == 4'(NMI_NUM));

   // ---------------- register writes ----------------
   logic        wr_ctrl, wr_en, wr_set, wr_clr, wr_base, wr_lo, wr_hi, wr_ret, wr_nret;
   logic [15:0] set_bits, clr_bits, take_bits, flag_d;

   assign wr_ctrl = reg_we_i && (reg_addr_i == RA_CTRL);
   assign wr_en   = reg_we_i && (reg_addr_i == RA_EN);
   assign wr_set  = reg_we_i && (reg_addr_i == RA_SET);
   assign wr_clr  = reg_we_i && (reg_addr_i == RA_CLR);
   assign wr_base = reg_we_i && (reg_addr_i == RA_BASE);
   assign wr_lo   = reg_we_i && (reg_addr_i == RA_SELLO);
   assign wr_hi   = reg_we_i && (reg_addr_i == RA_SELHI);
   assign wr_ret  = reg_we_i && (reg_addr_i == RA_RET);
   assign wr_nret = reg_we_i && (reg_addr_i == RA_NRET);

   assign set_bits  = wr_set ? reg_wdata_i[15:0] : '0;
   assign clr_bits  = wr_clr ? reg_wdata_i[15:0] : '0;
   assign take_bits = take ? (16'd1 << take_num) : '0;
   // new requests win over clears and over the entry clear
   assign flag_d = ((flag_q & ~clr_bits & ~take_bits) | set_bits | hw_evt) & IMPL_MASK;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q   <= '0;
         en_q     <= '0;
         gie_q    <= 1'b0;
         pgie_q   <= 1'b0;
         base_q   <= '0;
         sel_lo_q <= '0;
         sel_hi_q <= '0;
         irp_q    <= '0;
         nrp_q    <= '0;
         ack_q    <= 1'b0;
         inum_q   <= '0;
         vec_q    <= '0;
      end else begin
         flag_q <= flag_d;
         if (wr_en)   en_q     <= reg_wdata_i[15:0] & IMPL_MASK;
         if (wr_base) base_q   <= reg_wdata_i[ADDR_W-1:TABLE_ALIGN_W];
         if (wr_lo)   sel_lo_q <= reg_wdata_i & SEL_MASK;
         if (wr_hi)   sel_hi_q <= reg_wdata_i & SEL_MASK;

         if (take && !take_nmi) begin
            pgie_q <= gie_q;
            gie_q  <= 1'b0;
         end else if (rti_i) begin
            gie_q  <= pgie_q;
         end else if (wr_ctrl) begin
            gie_q  <= reg_wdata_i[0];
            pgie_q <= reg_wdata_i[1];
         end

         if (take && !take_nmi) irp_q <= ret_addr_i;
         else if (wr_ret)       irp_q <= reg_wdata_i;
         if (take_nmi)          nrp_q <= ret_addr_i;
         else if (wr_nret)      nrp_q <= reg_wdata_i;

         ack_q <= take;
         if (take) begin
            inum_q <= take_num;
            vec_q  <= {base_q, TABLE_ALIGN_W'(take_num) << ENTRY_SH};
         end
      end
   end

   assign ack_o  = ack_q;
   assign inum_o = inum_q;
   assign vec_o  = vec_q;

   // ---------------- register reads ----------------
   always_comb begin
      reg_rdata_o = '0;
      case (reg_addr_i)
         RA_CTRL:  reg_rdata_o = {30'd0, pgie_q, gie_q};
         RA_EN:    reg_rdata_o = {16'd0, en_q};
         RA_FLAG:  reg_rdata_o = {16'd0, flag_q};
         RA_BASE:  reg_rdata_o = {base_q, TABLE_ALIGN_W'(0)};
         RA_SELLO: reg_rdata_o = sel_lo_q;
         RA_SELHI: reg_rdata_o = sel_hi_q;
         RA_RET:   reg_rdata_o = irp_q;
         RA_NRET:  reg_rdata_o = nrp_q;
         default:  reg_rdata_o = '0;
      endcase
   end

   // ---------------- assertions ----------------
   a_r4_reserved_flags_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q & ~IMPL_MASK) == 16'd0);

   a_r10_reserved_en_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q & ~IMPL_MASK) == 16'd0);

   a_r5_taken_was_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_o && inum_o != 4'(NMI_NUM)) |->
         ($past(gie_q) && $past(en_q[NMI_NUM]) && (|($past(en_q) & (16'd1 << inum_o)))));

   a_r6_no_higher_pending: assert property (@(posedge clk) disable iff (!rst_n)
      ack_o |-> (($past(flag_q) & higher_mask(inum_o)) == 16'd0));

   a_r7_entry_saves_gie: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_o && inum_o != 4'(NMI_NUM)) |-> (!gie_q && (pgie_q == $past(gie_q))));

   a_r8_vector_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      ack_o |-> (vec_o[ENTRY_SH-1:0] == '0));

   a_r9_rti_restores: assert property (@(posedge clk) disable iff (!rst_n)
      (rti_i && !take) |=> (gie_q == $past(pgie_q)));
endmodule

// File: tb/tb_vec_intc.sv
module tb_vec_intc;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] src_i = '1;
   logic        nmi_i = 1'b1;
   logic [31:0] ret_addr_i = 32'h1234_5678;
   logic        rti_i = 1'b0;
   logic        reg_we_i = 1'b0;
   logic [3:0]  reg_addr_i = '0;
   logic [31:0] reg_wdata_i = '0;
   logic [31:0] reg_rdata_o;
   logic        ack_o;
   logic [3:0]  inum_o;
   logic [31:0] vec_o;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   vec_intc dut (.*);

   localparam logic [3:0] CTRL = 0, EN = 1, FLG = 2, SETR = 3, CLRR = 4,
                          BASE = 5, SLO = 6, SHI = 7, RET = 8, NRET = 9;

   function automatic logic [31:0] sel_mask();
      logic [31:0] m = '0;
      int pos[6] = '{0, 5, 10, 16, 21, 26};
      foreach (pos[i]) m[pos[i] +: 4] = 4'hF;
      return m;
   endfunction

   function automatic logic [3:0] next_pick(logic [15:0] p);
      if (p[1]) return 4'd1;
      for (int i = 4; i < 16; i++) if (p[i]) return 4'(i);
      return 4'd0;
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(logic [3:0] a, logic [31:0] d);
      @(negedge clk);
      reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
      @(negedge clk);
      reg_we_i = 1'b0;
   endtask

   task automatic rd(logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr_i = a;
      #0.1 d = reg_rdata_o;
   endtask

   task automatic rd_chk(string req, logic [3:0] a, logic [31:0] exp);
      logic [31:0] d;
      rd(a, d);
      check(req, d, exp);
   endtask

   task automatic set_line(int idx, logic v);
      if (idx == 16) nmi_i = v; else src_i[idx] = v;
   endtask

   // idx 16 = non-maskable line; clr != 0 writes the clear register on the event edge
   task automatic fire(int idx, bit shortp, logic [15:0] clr);
      @(negedge clk); set_line(idx, 1'b0);
      if (shortp) begin
         @(negedge clk); set_line(idx, 1'b1);
         repeat (5) @(negedge clk);
      end else begin
         @(negedge clk);
         @(negedge clk); set_line(idx, 1'b1);
         @(negedge clk);
         @(negedge clk);
         if (clr != 0) begin
            reg_we_i = 1'b1; reg_addr_i = CLRR; reg_wdata_i = {16'd0, clr};
         end
         @(negedge clk);
         reg_we_i = 1'b0;
      end
   endtask

   task automatic wait_ack(output bit got, output logic [3:0] n, output logic [31:0] v);
      got = 0; n = 'x; v = 'x;
      for (int i = 0; i < 12 && !got; i++) begin
         @(negedge clk);
         if (ack_o) begin got = 1; n = inum_o; v = vec_o; end
      end
   endtask

   task automatic expect_ack(string req, logic [3:0] en, logic [31:0] ev);
      bit g; logic [3:0] n; logic [31:0] v;
      wait_ack(g, n, v);
      check({req, " ack"}, 32'(g), 32'd1);
      check({req, " inum"}, 32'(n), 32'(en));
      check({req, " vector"}, v, ev);
   endtask

   task automatic expect_none(string req);
      bit g; logic [3:0] n; logic [31:0] v;
      wait_ack(g, n, v);
      check({req, " no ack"}, 32'(g), 32'd0);
   endtask

   task automatic pulse_rti();
      @(negedge clk); rti_i = 1'b1;
      @(negedge clk); rti_i = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] w, d;
      logic [15:0] pend;
      void'($urandom(32'd4242));
      repeat (5) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      @(negedge clk);
      check("R1 ack", 32'(ack_o), 0);
      check("R1 inum", 32'(inum_o), 0);
      check("R1 vec", vec_o, 0);
      rd_chk("R1 ctrl", CTRL, 0);
      rd_chk("R1 en", EN, 0);
      rd_chk("R1 flags", FLG, 0);
      rd_chk("R1 base", BASE, 0);
      rd_chk("R1 sello", SLO, 0);
      rd_chk("R1 selhi", SHI, 0);

      // R3 selector field layout, random
      for (int i = 0; i < 8; i++) begin
         w = $urandom;
         wr(SLO, w); rd_chk("R3 sello mask", SLO, w & sel_mask());
         w = $urandom;
         wr(SHI, w); rd_chk("R3 selhi mask", SHI, w & sel_mask());
      end

      // routing: INT4<-src5, INT9<-src13, INT10<-src13
      wr(SLO, 32'd5 | (32'd13 << 26));
      wr(SHI, 32'd13);
      fire(5, 1'b1, 0);
      rd_chk("R2 short pulse ignored", FLG, 0);
      fire(5, 1'b0, 0);
      rd_chk("R2 R3 src5 to int4", FLG, 32'h0010);
      wr(CLRR, 32'hFFFF);
      fire(13, 1'b0, 0);
      rd_chk("R3 src13 to int9 and int10", FLG, 32'h0600);
      wr(CLRR, 32'hFFFF);
      rd_chk("R4 clear all", FLG, 0);

      // R4 set/clear/read-only/reserved
      wr(SETR, 32'h00F0); rd_chk("R4 set", FLG, 32'h00F0);
      wr(FLG, 32'hFFFF);  rd_chk("R4 flags read only", FLG, 32'h00F0);
      wr(SETR, 32'h000D); rd_chk("R4 reserved bits", FLG, 32'h00F0);
      wr(CLRR, 32'h0030); rd_chk("R4 clear", FLG, 32'h00C0);
      wr(CLRR, 32'hFFFF);
      fire(5, 1'b0, 16'h0010);
      rd_chk("R4 event beats clear", FLG, 32'h0010);
      wr(CLRR, 32'hFFFF);

      // R10 enable independence
      wr(EN, 32'hFFFF); rd_chk("R10 enable reserved", EN, 32'hFFF2);
      wr(CTRL, 1);      rd_chk("R10 gie on keeps enables", EN, 32'hFFF2);
      wr(CTRL, 0);      rd_chk("R10 gie off keeps enables", EN, 32'hFFF2);
      for (int i = 0; i < 6; i++) begin
         w = $urandom;
         wr(EN, w);
         wr(CTRL, 32'($urandom_range(0, 3)));
         rd_chk("R10 random enables", EN, w & 32'hFFF2);
      end
      wr(CTRL, 0);

      // R5 R7 R8 maskable entry with relocated base
      wr(BASE, 32'h0000_0800);
      wr(EN, 32'h0042);
      wr(SETR, 32'h0040);
      expect_none("R5 gie off");
      rd_chk("R5 flag kept", FLG, 32'h0040);
      wr(CTRL, 1);
      expect_ack("R5 R8 int6", 4'd6, 32'h0000_08C0);
      rd_chk("R7 ctrl after entry", CTRL, 32'h2);
      rd_chk("R7 return address", RET, 32'h1234_5678);
      rd_chk("R7 flag cleared", FLG, 0);
      pulse_rti();
      rd_chk("R9 rti restores gie", CTRL, 32'h3);

      // R5 gating conditions
      wr(CTRL, 0);
      wr(EN, 32'h0040);
      wr(SETR, 32'h0040);
      wr(CTRL, 1);
      expect_none("R5 nmie off");
      wr(EN, 32'h0002);
      expect_none("R5 own enable off");
      wr(SETR, 32'h0020);
      wr(EN, 32'h0042);
      expect_none("R5 blocked by disabled higher flag");
      wr(CLRR, 32'h0020);
      expect_ack("R5 unblocked int6", 4'd6, 32'h0000_08C0);
      pulse_rti();

      // R6 priority order
      wr(CTRL, 0);
      wr(EN, 32'hFFF2);
      wr(SETR, 32'h0210);
      wr(CTRL, 1);
      expect_ack("R6 int4 first", 4'd4, 32'h0000_0880);
      expect_none("R6 gie cleared by entry");
      pulse_rti();
      expect_ack("R6 int9 next", 4'd9, 32'h0000_0920);
      pulse_rti();

      // R11 non-maskable with everything off
      wr(CTRL, 0);
      wr(EN, 0);
      ret_addr_i = 32'hCAFE_0040;
      wr(SETR, 32'h0002);
      expect_ack("R11 nmi ignores enables", 4'd1, 32'h0000_0820);
      rd_chk("R7 nmi return", NRET, 32'hCAFE_0040);
      rd_chk("R7 nmi ctrl unchanged", CTRL, 0);

      // R6 nmi outranks maskable, both set together
      wr(EN, 32'hFFF2);
      wr(CTRL, 1);
      wr(SETR, 32'h0012);
      expect_ack("R6 nmi before int4", 4'd1, 32'h0000_0820);
      expect_ack("R6 int4 after nmi", 4'd4, 32'h0000_0880);
      pulse_rti();

      // R2 non-maskable pin
      fire(16, 1'b0, 0);
      expect_ack("R2 nmi pin", 4'd1, 32'h0000_0820);

      // R8 base lower bits dropped
      wr(BASE, 32'h0000_0BFF);
      rd_chk("R8 base alignment", BASE, 32'h0000_0800);

      // random drain order
      for (int it = 0; it < 30; it++) begin
         wr(CTRL, 0);
         w = $urandom;
         pend = (w[15:0] & 16'hFFF0) | 16'h0010;
         ret_addr_i = $urandom;
         wr(SETR, {16'd0, pend});
         wr(CTRL, 1);
         while (pend != 0) begin
            logic [3:0] e;
            e = next_pick(pend);
            expect_ack("R6 random order", e, 32'h0000_0800 + 32'(e) * 32);
            pend[e] = 1'b0;
            pulse_rti();
         end
         rd_chk("R7 random drained", FLG, 0);
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule